// File: doc/BRIEF.md
# Processor-to-Host Bus Cycle Adapter

This block lets a 32-bit processor with dynamic bus sizing run cycles on a legacy 16-bit asynchronous host bus. It watches the processor address strobe, transfer size and address bit 0. From these it produces registered host address and data strobes, one for each byte lane. The host 16-bit data bus sits on the upper processor lanes, bits 16 to 31. Every host cycle is answered as a 16-bit port, so the processor sizes its own transfers to match.

Slow 6800-type peripherals report themselves with a valid-peripheral input. For these the block runs a synchronous cycle against a locally generated E clock and drives the valid-memory strobe. It acknowledges only when E falls. Host bus requests and grant acknowledges reach the processor through two-flop synchronisers. The processor grant goes back to the host on a register. While another master owns the bus, the host-side strobes are released.

Top module: `cpu_bus_adapter`

## Requirements
- R1: Host strobes follow size and A0. With size 01 (byte), A0=0 asserts only the upper strobe and A0=1 asserts only the lower strobe. With any other size (00 long, 10 word, 11 three-byte), A0=0 asserts both strobes and A0=1 asserts only the lower strobe.
- R2: Host address strobe and data strobes assert on the first clock edge at which the processor address strobe is seen low, provided the bus is not granted away.
- R3: Processor acknowledge 16 (`cpu_dsack1_no`) asserts one clock after host data acknowledge is seen low during an ordinary cycle. Acknowledge 8 (`cpu_dsack0_no`) is never asserted.
- R4: Within one clock after the processor negates its address strobe, the host address and data strobes, the valid-memory strobe and the acknowledge are all negated.
- R5: The E clock divides the host clock by E_DIV=10, staying low for 6 clocks and high for 4. It is low for the first 5 clocks after reset release and high from clock 6 to clock 9.
- R6: When valid-peripheral is low during a cycle, the valid-memory strobe asserts on the same edge on which E goes low. The acknowledge asserts on the next falling edge of E, exactly E_DIV clocks later.
- R7: Read data from the host appears on processor lanes 31:16, with lanes 15:0 driven zero. Host write data is taken from processor lanes 31:16.
- R8: Host bus request and grant acknowledge reach the processor after exactly two clock edges.
- R9: The processor bus grant reaches the host one clock edge later.
- R10: While the synchronised grant acknowledge is low, `host_drive_o` is low, meaning the host strobes are high impedance. A processor address strobe in that state starts no host cycle.
- R11: During reset every strobe and acknowledge is negated, E is low and `host_drive_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_as_ni | input | 1 | Processor address strobe, active low |
| cpu_siz_i | input | 2 | Processor transfer size |
| cpu_a0_i | input | 1 | Processor address bit 0 |
| cpu_wdata_i | input | 32 | Processor write data |
| cpu_rdata_o | output | 32 | Read data to processor |
| cpu_dsack1_no | output | 1 | 16-bit port acknowledge, active low |
| cpu_dsack0_no | output | 1 | 8-bit port acknowledge, held high |
| cpu_br_no | output | 1 | Synchronised bus request to processor |
| cpu_bgack_no | output | 1 | Synchronised grant acknowledge to processor |
| cpu_bg_ni | input | 1 | Processor bus grant |
| host_as_no | output | 1 | Host address strobe |
| host_uds_no | output | 1 | Host upper data strobe |
| host_lds_no | output | 1 | Host lower data strobe |
| host_drive_o | output | 1 | Host strobe output enable; low means high impedance |
| host_wdata_o | output | 16 | Write data to host |
| host_rdata_i | input | 16 | Read data from host |
| host_dtack_ni | input | 1 | Host data acknowledge |
| host_vpa_ni | input | 1 | Valid peripheral address |
| host_vma_no | output | 1 | Valid memory address strobe |
| host_e_o | output | 1 | Peripheral E clock |
| host_br_ni | input | 1 | Host bus request |
| host_bgack_ni | input | 1 | Host bus grant acknowledge |
| host_bg_no | output | 1 | Bus grant to host |

## Verification
A cycle state that is stuck or wrong shows at the ports in one of two ways. Either an acknowledge never arrives, or it arrives one clock off from host data acknowledge or from the falling edge of E, so each check samples the clock right after the expected edge. A slipped E divider shows within one E period as a low or high phase of the wrong length. It also shows as a valid-memory strobe asserting while E is high. Wrong lane decoding shows up in the first clock of a cycle, because the strobes are registered directly from size and A0.

// File: rtl/cba_pkg.sv
package cba_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_VPA_WAIT,
    ST_VMA,
    ST_ACK
  } cyc_state_e;

  localparam logic [1:0] SIZ_BYTE = 2'b01;
endpackage

// File: rtl/cba_sync2.sv
module cba_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/cba_eclock.sv
module cba_eclock #(
  parameter int E_DIV  = 10,
  parameter int E_HIGH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic e_o,
  output logic last_o
);
  localparam int E_LOW = E_DIV - E_HIGH;
  localparam int CW    = $clog2(E_DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          e_q;

  assign last_o = (cnt_q == CW'(E_DIV - 1));
  assign cnt_d  = last_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      e_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      e_q   <= (cnt_d >= CW'(E_LOW));
    end
  end

  assign e_o = e_q;
endmodule

// File: rtl/cba_cycle_fsm.sv
module cba_cycle_fsm
  import cba_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpu_as_ni,
  input  logic [1:0] cpu_siz_i,
  input  logic       cpu_a0_i,
  input  logic       bus_owned_i,
  input  logic       host_dtack_ni,
  input  logic       host_vpa_ni,
  input  logic       e_last_i,
  output logic       as_no,
  output logic       uds_no,
  output logic       lds_no,
  output logic       vma_no,
  output logic       dsack1_no
);
  cyc_state_e st_q;
  logic       uds_n_d, lds_n_d;

  // 16-bit port lane select
  assign uds_n_d = cpu_a0_i;
  assign lds_n_d = ~(cpu_a0_i | (cpu_siz_i != SIZ_BYTE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      as_no     <= 1'b1;
      uds_no    <= 1'b1;
      lds_no    <= 1'b1;
      vma_no    <= 1'b1;
      dsack1_no <= 1'b1;
    end else if (st_q != ST_IDLE && cpu_as_ni) begin
      st_q      <= ST_IDLE;
      as_no     <= 1'b1;
      uds_no    <= 1'b1;
      lds_no    <= 1'b1;
      vma_no    <= 1'b1;
      dsack1_no <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (!cpu_as_ni && bus_owned_i) begin
          st_q   <= ST_RUN;
          as_no  <= 1'b0;
          uds_no <= uds_n_d;
          lds_no <= lds_n_d;
        end
        ST_RUN: begin
          if (!host_vpa_ni) begin
            st_q <= ST_VPA_WAIT;
          end else if (!host_dtack_ni) begin
            st_q      <= ST_ACK;
            dsack1_no <= 1'b0;
          end
        end
        ST_VPA_WAIT: if (e_last_i) begin
          st_q   <= ST_VMA;
          vma_no <= 1'b0;
        end
        ST_VMA: if (e_last_i) begin
          st_q      <= ST_ACK;
          dsack1_no <= 1'b0;
        end
        ST_ACK: ;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpu_bus_adapter.sv
module cpu_bus_adapter #(
  parameter int E_DIV  = 10,
  parameter int E_HIGH = 4,
  parameter int HOST_W = 16,
  parameter int CPU_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_as_ni,
  input  logic [1:0]        cpu_siz_i,
  input  logic              cpu_a0_i,
  input  logic [CPU_W-1:0]  cpu_wdata_i,
  output logic [CPU_W-1:0]  cpu_rdata_o,
  output logic              cpu_dsack1_no,
  output logic              cpu_dsack0_no,
  output logic              cpu_br_no,
  output logic              cpu_bgack_no,
  input  logic              cpu_bg_ni,
  output logic              host_as_no,
  output logic              host_uds_no,
  output logic              host_lds_no,
  output logic              host_drive_o,
  output logic [HOST_W-1:0] host_wdata_o,
  input  logic [HOST_W-1:0] host_rdata_i,
  input  logic              host_dtack_ni,
  input  logic              host_vpa_ni,
  output logic              host_vma_no,
  output logic              host_e_o,
  input  logic              host_br_ni,
  input  logic              host_bgack_ni,
  output logic              host_bg_no
);
  localparam int LANE_LO = CPU_W - HOST_W;

  logic [1:0] arb_sync;
  logic       e_last;
  logic       bg_q;

  cba_sync2 #(.WIDTH(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_bgack_ni, host_br_ni}),
    .q_o   (arb_sync)
  );

  assign cpu_br_no    = arb_sync[0];
  assign cpu_bgack_no = arb_sync[1];
  assign host_drive_o = arb_sync[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bg_q <= 1'b1;
    else         bg_q <= cpu_bg_ni;
  end
  assign host_bg_no = bg_q;

  cba_eclock #(.E_DIV(E_DIV), .E_HIGH(E_HIGH)) i_eclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .e_o   (host_e_o),
    .last_o(e_last)
  );

  cba_cycle_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_as_ni    (cpu_as_ni),
    .cpu_siz_i    (cpu_siz_i),
    .cpu_a0_i     (cpu_a0_i),
    .bus_owned_i  (arb_sync[1]),
    .host_dtack_ni(host_dtack_ni),
    .host_vpa_ni  (host_vpa_ni),
    .e_last_i     (e_last),
    .as_no        (host_as_no),
    .uds_no       (host_uds_no),
    .lds_no       (host_lds_no),
    .vma_no       (host_vma_no),
    .dsack1_no    (cpu_dsack1_no)
  );

  assign cpu_dsack0_no = 1'b1;

  // host lanes ride on the upper processor lanes
  assign cpu_rdata_o  = {host_rdata_i, {LANE_LO{1'b0}}};
  assign host_wdata_o = cpu_wdata_i[CPU_W-1:LANE_LO];
endmodule

// File: rtl/cpu_bus_adapter_checker.sv
module cpu_bus_adapter_checker #(
  parameter int E_HIGH = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cpu_as_ni,
  input logic cpu_dsack1_no,
  input logic cpu_dsack0_no,
  input logic host_as_no,
  input logic host_uds_no,
  input logic host_lds_no,
  input logic host_drive_o,
  input logic host_dtack_ni,
  input logic host_vma_no,
  input logic host_e_o
);
  logic [7:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_cnt_q <= '0;
    else if (host_e_o) hi_cnt_q <= hi_cnt_q + 1'b1;
    else               hi_cnt_q <= '0;
  end

  assert_host_as_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_as_no) |-> $past(!cpu_as_ni));

  assert_dsack0_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_dsack0_no);

  assert_dsack_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_dsack1_no) |-> ($past(!host_dtack_ni) || !host_vma_no));

  assert_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_as_ni) |=> (host_as_no && host_uds_no && host_lds_no && host_vma_no && cpu_dsack1_no));

  assert_e_high_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_e_o) |-> (hi_cnt_q == 8'(E_HIGH)));

  assert_vma_on_e_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_vma_no) |-> !host_e_o);

  assert_no_cycle_granted_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_drive_o |-> host_as_no);
endmodule

bind cpu_bus_adapter cpu_bus_adapter_checker #(.E_HIGH(E_HIGH)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_as_ni    (cpu_as_ni),
  .cpu_dsack1_no(cpu_dsack1_no),
  .cpu_dsack0_no(cpu_dsack0_no),
  .host_as_no   (host_as_no),
  .host_uds_no  (host_uds_no),
  .host_lds_no  (host_lds_no),
  .host_drive_o (host_drive_o),
  .host_dtack_ni(host_dtack_ni),
  .host_vma_no  (host_vma_no),
  .host_e_o     (host_e_o)
);

// File: tb/test_cpu_bus_adapter.sv
module test_cpu_bus_adapter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_as_ni = 1'b1;
  logic [1:0]  cpu_siz_i = 2'b10;
  logic        cpu_a0_i = 1'b0;
  logic [31:0] cpu_wdata_i = '0;
  logic [31:0] cpu_rdata_o;
  logic        cpu_dsack1_no, cpu_dsack0_no, cpu_br_no, cpu_bgack_no;
  logic        cpu_bg_ni = 1'b1;
  logic        host_as_no, host_uds_no, host_lds_no, host_drive_o;
  logic [15:0] host_wdata_o;
  logic [15:0] host_rdata_i = '0;
  logic        host_dtack_ni = 1'b1, host_vpa_ni = 1'b1;
  logic        host_vma_no, host_e_o, host_bg_no;
  logic        host_br_ni = 1'b1, host_bgack_ni = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cpu_bus_adapter i_cpu_bus_adapter (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_as_ni(cpu_as_ni), .cpu_siz_i(cpu_siz_i), .cpu_a0_i(cpu_a0_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .cpu_dsack1_no(cpu_dsack1_no), .cpu_dsack0_no(cpu_dsack0_no),
    .cpu_br_no(cpu_br_no), .cpu_bgack_no(cpu_bgack_no), .cpu_bg_ni(cpu_bg_ni),
    .host_as_no(host_as_no), .host_uds_no(host_uds_no), .host_lds_no(host_lds_no),
    .host_drive_o(host_drive_o), .host_wdata_o(host_wdata_o), .host_rdata_i(host_rdata_i),
    .host_dtack_ni(host_dtack_ni), .host_vpa_ni(host_vpa_ni), .host_vma_no(host_vma_no),
    .host_e_o(host_e_o), .host_br_ni(host_br_ni), .host_bgack_ni(host_bgack_ni),
    .host_bg_no(host_bg_no)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {siz[1:0], a0, exp_uds_n, exp_lds_n}
  localparam logic [4:0] VEC [8] = '{
    5'b00_0_00, 5'b00_1_10, 5'b01_0_01, 5'b01_1_10,
    5'b10_0_00, 5'b10_1_10, 5'b11_0_00, 5'b11_1_10
  };

  initial begin : watchdog
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    // R11 reset state
    check("R11 strobes", {host_as_no, host_uds_no, host_lds_no, host_vma_no}, 4'hF);
    check("R11 acks", {cpu_dsack1_no, cpu_dsack0_no, host_e_o, host_drive_o}, 4'b1101);
    rst_ni = 1'b1;

    // R5 E phase after reset release
    for (int k = 1; k <= 10; k++) begin
      tick();
      check("R5 E phase", host_e_o, (k % 10) >= 6);
    end

    // R1 R2 R3 R4 table of ordinary cycles
    for (int v = 0; v < 8; v++) begin
      cpu_siz_i = VEC[v][4:3];
      cpu_a0_i  = VEC[v][2];
      cpu_as_ni = 1'b0;
      tick();
      check("R2 host as", host_as_no, 1'b0);
      check("R1 strobes", {host_uds_no, host_lds_no}, VEC[v][1:0]);
      check("R3 no early ack", cpu_dsack1_no, 1'b1);
      host_dtack_ni = 1'b0;
      tick();
      check("R3 dsack1", cpu_dsack1_no, 1'b0);
      check("R3 dsack0", cpu_dsack0_no, 1'b1);
      cpu_as_ni = 1'b1;
      tick();
      host_dtack_ni = 1'b1;
      check("R4 release", {host_as_no, host_uds_no, host_lds_no, cpu_dsack1_no}, 4'hF);
    end

    // R7 lanes
    host_rdata_i = 16'hA55A;
    cpu_wdata_i  = 32'h1234_5678;
    tick();
    check("R7 read lanes", cpu_rdata_o, 32'hA55A_0000);
    check("R7 write lanes", host_wdata_o, 32'h0000_1234);

    // R6 peripheral cycle
    begin : vpa_cycle
      logic prev_e;
      int   t_vma;
      int   t_ack;
      t_vma = -1;
      t_ack = -1;
      cpu_siz_i = 2'b01;
      cpu_a0_i  = 1'b1;
      cpu_as_ni = 1'b0;
      tick();
      host_vpa_ni = 1'b0;
      prev_e = host_e_o;
      for (int t = 0; t < 40 && t_ack < 0; t++) begin
        tick();
        if (t_vma < 0 && !host_vma_no) begin
          t_vma = t;
          check("R6 vma on E fall", {prev_e, host_e_o}, 2'b10);
        end
        if (!cpu_dsack1_no) begin
          t_ack = t;
          check("R6 ack on E fall", {prev_e, host_e_o, host_vma_no}, 3'b100);
        end
        prev_e = host_e_o;
      end
      check("R6 ack delay", t_ack - t_vma, 10);
      cpu_as_ni = 1'b1;
      tick();
      host_vpa_ni = 1'b1;
      check("R4 vpa release", {host_vma_no, cpu_dsack1_no, host_as_no}, 3'b111);
    end

    // R8 synchronisers
    host_br_ni = 1'b0;
    tick();
    check("R8 br one edge", cpu_br_no, 1'b1);
    tick();
    check("R8 br two edges", cpu_br_no, 1'b0);
    host_br_ni = 1'b1;

    // R9 grant passthrough
    cpu_bg_ni = 1'b0;
    check("R9 bg before edge", host_bg_no, 1'b1);
    tick();
    check("R9 bg", host_bg_no, 1'b0);
    cpu_bg_ni = 1'b1;

    // R10 bus granted away
    host_bgack_ni = 1'b0;
    tick();
    check("R8 bgack one edge", cpu_bgack_no, 1'b1);
    tick();
    check("R8 bgack two edges", cpu_bgack_no, 1'b0);
    check("R10 drive off", host_drive_o, 1'b0);
    cpu_as_ni = 1'b0;
    tick(3);
    check("R10 no cycle", {host_as_no, host_uds_no, host_lds_no, cpu_dsack1_no}, 4'hF);
    cpu_as_ni = 1'b1;
    host_bgack_ni = 1'b1;
    tick(3);
    check("R10 drive back", host_drive_o, 1'b1);

    // R11 reset mid-cycle
    cpu_as_ni = 1'b0;
    tick();
    check("R2 cycle before reset", host_as_no, 1'b0);
    rst_ni = 1'b0;
    #1;
    check("R11 reset clears", {host_as_no, host_uds_no, host_lds_no, host_e_o}, 4'b1110);
    cpu_as_ni = 1'b1;
    tick();
    rst_ni = 1'b1;
    tick(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule